// File: doc/BRIEF.md
# PHY Reset and Receive-PLL Lock Sequencer

This block brings a serial PHY out of reset and confirms that its receive PLL has settled. It does this without touching the PHY's control handshake directly. Instead it sends a short list of commands to a separate handshake master, which carries out each register access.

When it is started from idle, the sequencer first selects the PHY clock/reset register and sends a write with the reset bit set. That write is not acknowledged, because a PHY in reset cannot answer. The sequencer then polls the lane status register. Each poll is a fixed quiet gap, then an address command, then a read command. Polling ends in one of three ways:

- the lock bit appears in the read data, which is success;
- the retry budget runs out, which is a timeout;
- the handshake master reports an error on an address or read step, which is an immediate abort.

When the sequence ends, a single-cycle `done` is raised. The two result flags are valid in that same cycle and stay held until the next start.

Top module: `phy_lock_seq`

## Requirements
- R1: After reset, `done`, `cmdStart`, `timeoutErr` and `linkErr` are all low.
- R2: A start accepted from idle first issues an address command (`cmdOp` = 0) carrying `RST_REG_ADDR` (default 0x7F3F). It then issues a write command (`cmdOp` = 1) carrying `RST_REG_VAL` (default 0x0001, bit 0 = PHY reset).
- R3: The reset write does not wait for `cmdDone`. Any `cmdDone` or `cmdErr` that arrives after the write and before the next address command has no effect on the sequence or its outcome.
- R4: Each poll begins with an address command carrying `STAT_REG_ADDR` (default 0x2003), followed by a read command (`cmdOp` = 2). That address command is issued exactly `POLL_DELAY`+1 cycles after the cycle of the reset write command, or after the cycle in which the previous read's `cmdDone` was presented. No command is issued in between.
- R5: A read that completes without error and has bit `LOCK_BIT` (default 1) of `cmdRdData` set ends the sequence with success. Both error flags are low and no further command is issued.
- R6: At most `MAX_POLLS` reads are issued. If none of them shows the lock bit, the sequence ends with `timeoutErr` high.
- R7: `cmdErr` presented with `cmdDone` on any address or read step ends the sequence at once with `linkErr` high and no further command. This error takes precedence over a lock bit in the same read data.
- R8: `done` is high for exactly one cycle per sequence. `timeoutErr` and `linkErr` are valid in that cycle, are never high together, and hold until the next accepted start.
- R9: `start` is ignored while a sequence is running.
- R10: `cmdStart` is a one-cycle pulse, and `cmdOp` and `cmdData` are valid in the cycle it is high. Each step waits for its `cmdDone` before the next command, except the reset write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence (accepted from idle only) |
| done | output | 1 | One-cycle end-of-sequence pulse |
| timeoutErr | output | 1 | Lock was never seen within the poll budget |
| linkErr | output | 1 | Handshake master reported an error |
| cmdStart | output | 1 | Command request pulse to the handshake master |
| cmdOp | output | 2 | Command kind: 0 address, 1 write, 2 read |
| cmdData | output | DATA_W | Register address or write data |
| cmdDone | input | 1 | Command completion from the handshake master |
| cmdErr | input | 1 | Command error, qualified by `cmdDone` |
| cmdRdData | input | DATA_W | Read data, qualified by `cmdDone` |

## Verification
The bench builds the sequencer with `POLL_DELAY` = 6 and `MAX_POLLS` = 5. The short gap keeps each run brief while still exceeding the longest stray response the bench injects after the reset write. With only five polls, the timeout path, a lock on the final allowed poll, and errors on every poll index all come up often in the random runs. Alongside the parameter settings:

- The quiet-gap length is measured in cycles against the parameter.
- The command stream is compared entry by entry with the expected order.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  typedef enum logic [1:0] {
    OP_ADDR  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } cmd_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RST_ADDR,
    S_RST_ADDR_WAIT,
    S_RST_WRITE,
    S_GAP,
    S_STAT_ADDR,
    S_STAT_ADDR_WAIT,
    S_READ,
    S_READ_WAIT,
    S_FINISH
  } seq_state_e;

  typedef struct packed {
    logic clearRun;
    logic issueRstAddr;
    logic issueRstWrite;
    logic issueStatAddr;
    logic issueRead;
    logic loadGap;
    logic tickGap;
    logic setTimeout;
    logic setLinkErr;
  } seq_strobe_t;

endpackage

// File: rtl/phy_seq_ctrl.sv
module phy_seq_ctrl
  import phy_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        cmdDone,
  input  logic        cmdErr,
  input  logic        gapDone,
  input  logic        lastPoll,
  input  logic        lockSeen,
  output seq_strobe_t stb,
  output logic        done
);

  seq_state_e state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    stb = '0;
    nxt = state;
    case (state)
      S_IDLE: begin
        if (start) begin
          stb.clearRun = 1'b1;
          nxt = S_RST_ADDR;
        end
      end
      S_RST_ADDR: begin
        stb.issueRstAddr = 1'b1;
        nxt = S_RST_ADDR_WAIT;
      end
      S_RST_ADDR_WAIT: begin
        if (cmdDone) begin
          if (cmdErr) begin
            stb.setLinkErr = 1'b1;
            nxt = S_FINISH;
          end else begin
            nxt = S_RST_WRITE;
          end
        end
      end
      S_RST_WRITE: begin
        stb.issueRstWrite = 1'b1;
        stb.loadGap = 1'b1;
        nxt = S_GAP;
      end
      S_GAP: begin
        if (gapDone) nxt = S_STAT_ADDR;
        else         stb.tickGap = 1'b1;
      end
      S_STAT_ADDR: begin
        stb.issueStatAddr = 1'b1;
        nxt = S_STAT_ADDR_WAIT;
      end
      S_STAT_ADDR_WAIT: begin
        if (cmdDone) begin
          if (cmdErr) begin
            stb.setLinkErr = 1'b1;
            nxt = S_FINISH;
          end else begin
            nxt = S_READ;
          end
        end
      end
      S_READ: begin
        stb.issueRead = 1'b1;
        nxt = S_READ_WAIT;
      end
      S_READ_WAIT: begin
        if (cmdDone) begin
          if (cmdErr) begin
            stb.setLinkErr = 1'b1;
            nxt = S_FINISH;
          end else if (lockSeen) begin
            nxt = S_FINISH;
          end else if (lastPoll) begin
            stb.setTimeout = 1'b1;
            nxt = S_FINISH;
          end else begin
            stb.loadGap = 1'b1;
            nxt = S_GAP;
          end
        end
      end
      S_FINISH: nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  assign done = (state == S_FINISH);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE && start) |=> (state != S_RST_ADDR));

  // R7
  abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == S_READ_WAIT || state == S_STAT_ADDR_WAIT) && cmdDone && cmdErr) |=> done);

endmodule

// File: rtl/phy_seq_dpath.sv
module phy_seq_dpath
  import phy_seq_pkg::*;
#(
  parameter int unsigned             DATA_W        = 16,
  parameter logic [DATA_W-1:0]       RST_REG_ADDR  = 'h7F3F,
  parameter logic [DATA_W-1:0]       RST_REG_VAL   = 'h0001,
  parameter logic [DATA_W-1:0]       STAT_REG_ADDR = 'h2003,
  parameter int unsigned             MAX_POLLS     = 10,
  parameter int unsigned             POLL_DELAY    = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       stb,
  input  logic              lockBit,
  output logic              gapDone,
  output logic              lastPoll,
  output logic              lockSeen,
  output logic              cmdStart,
  output logic [1:0]        cmdOp,
  output logic [DATA_W-1:0] cmdData,
  output logic              timeoutErr,
  output logic              linkErr
);

  localparam int unsigned CNT_W = $clog2(MAX_POLLS + 1);
  localparam int unsigned GAP_W = (POLL_DELAY > 1) ? $clog2(POLL_DELAY) : 1;

  logic [CNT_W-1:0] pollCnt;
  logic [GAP_W-1:0] gapCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pollCnt <= '0;
    end else if (stb.clearRun) begin
      pollCnt <= '0;
    end else if (stb.issueRead) begin
      pollCnt <= pollCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (stb.loadGap) begin
      gapCnt <= GAP_W'(POLL_DELAY - 1);
    end else if (stb.tickGap) begin
      gapCnt <= gapCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeoutErr <= 1'b0;
      linkErr    <= 1'b0;
    end else if (stb.clearRun) begin
      timeoutErr <= 1'b0;
      linkErr    <= 1'b0;
    end else begin
      if (stb.setTimeout) timeoutErr <= 1'b1;
      if (stb.setLinkErr) linkErr    <= 1'b1;
    end
  end

  assign gapDone  = (gapCnt == '0);
  assign lastPoll = (pollCnt == CNT_W'(MAX_POLLS));
  assign lockSeen = lockBit;

  assign cmdStart = stb.issueRstAddr | stb.issueRstWrite | stb.issueStatAddr | stb.issueRead;

  always_comb begin
    cmdOp   = 2'(OP_ADDR);
    cmdData = '0;
    if (stb.issueRstAddr) begin
      cmdOp   = 2'(OP_ADDR);
      cmdData = RST_REG_ADDR;
    end else if (stb.issueRstWrite) begin
      cmdOp   = 2'(OP_WRITE);
      cmdData = RST_REG_VAL;
    end else if (stb.issueStatAddr) begin
      cmdOp   = 2'(OP_ADDR);
      cmdData = STAT_REG_ADDR;
    end else if (stb.issueRead) begin
      cmdOp   = 2'(OP_READ);
    end
  end

  // R6
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt <= CNT_W'(MAX_POLLS));

  // R4
  gap_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gapCnt != '0) |-> !cmdStart);

  // R10
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |=> !cmdStart);

  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(timeoutErr && linkErr));

endmodule

// File: rtl/phy_lock_seq.sv
module phy_lock_seq
  import phy_seq_pkg::*;
#(
  parameter int unsigned       DATA_W        = 16,
  parameter logic [DATA_W-1:0] RST_REG_ADDR  = 'h7F3F,
  parameter logic [DATA_W-1:0] RST_REG_VAL   = 'h0001,
  parameter logic [DATA_W-1:0] STAT_REG_ADDR = 'h2003,
  parameter int unsigned       LOCK_BIT      = 1,
  parameter int unsigned       MAX_POLLS     = 10,
  parameter int unsigned       POLL_DELAY    = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              done,
  output logic              timeoutErr,
  output logic              linkErr,
  output logic              cmdStart,
  output logic [1:0]        cmdOp,
  output logic [DATA_W-1:0] cmdData,
  input  logic              cmdDone,
  input  logic              cmdErr,
  input  logic [DATA_W-1:0] cmdRdData
);

  seq_strobe_t stb;
  logic gapDone, lastPoll, lockSeen;

  phy_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .cmdDone  (cmdDone),
    .cmdErr   (cmdErr),
    .gapDone  (gapDone),
    .lastPoll (lastPoll),
    .lockSeen (lockSeen),
    .stb      (stb),
    .done     (done)
  );

  phy_seq_dpath #(
    .DATA_W        (DATA_W),
    .RST_REG_ADDR  (RST_REG_ADDR),
    .RST_REG_VAL   (RST_REG_VAL),
    .STAT_REG_ADDR (STAT_REG_ADDR),
    .MAX_POLLS     (MAX_POLLS),
    .POLL_DELAY    (POLL_DELAY)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .lockBit    (cmdRdData[LOCK_BIT]),
    .gapDone    (gapDone),
    .lastPoll   (lastPoll),
    .lockSeen   (lockSeen),
    .cmdStart   (cmdStart),
    .cmdOp      (cmdOp),
    .cmdData    (cmdData),
    .timeoutErr (timeoutErr),
    .linkErr    (linkErr)
  );

endmodule

// File: tb/test_phy_lock_seq.sv
module test_phy_lock_seq;

  localparam int PD = 6;
  localparam int MP = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startMain = 1'b0;
  logic busyPoke = 1'b0;
  logic start;
  logic done, timeoutErr, linkErr, cmdStart;
  logic [1:0] cmdOp;
  logic [15:0] cmdData;
  logic cmdDone = 1'b0;
  logic cmdErr = 1'b0;
  logic [15:0] cmdRdData = '0;

  assign start = startMain | busyPoke;

  always #2.5 clk = ~clk;

  phy_lock_seq #(.POLL_DELAY(PD), .MAX_POLLS(MP)) i_phy_lock_seq (
    .clk(clk), .rstN(rstN), .start(start), .done(done),
    .timeoutErr(timeoutErr), .linkErr(linkErr), .cmdStart(cmdStart),
    .cmdOp(cmdOp), .cmdData(cmdData), .cmdDone(cmdDone),
    .cmdErr(cmdErr), .cmdRdData(cmdRdData)
  );

  int nChecks = 0;
  int nFails = 0;
  int cyc = 0;
  int lastRef = 0;
  int nCmd = 0, addrIdx = 0, readIdx = 0;
  int lockAt = 0, errKind = 0, errIdx = 0;
  bit strayWrite = 0, pokeBusy = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic respond(input bit err, input logic [15:0] data, input bit isRead);
    int lat = 1 + int'($urandom % 3);
    repeat (lat) @(posedge clk);
    #1;
    cmdDone = 1'b1; cmdErr = err; cmdRdData = data;
    if (isRead) lastRef = cyc;
    @(posedge clk); #1;
    cmdDone = 1'b0; cmdErr = 1'b0; cmdRdData = $urandom;
  endtask

  task automatic handleCmd();
    logic [1:0] op = cmdOp;
    logic [15:0] dat = cmdData;
    logic [15:0] rd;
    int n = nCmd;
    nCmd++;
    if (n == 0) begin
      chk(op == 2'd0, "R2 reset addr op", op, 0);
      chk(dat == 16'h7F3F, "R2 reset addr data", dat, 16'h7F3F);
    end else if (n == 1) begin
      chk(op == 2'd1, "R2 write op", op, 1);
      chk(dat == 16'h0001, "R2 write data", dat, 16'h0001);
    end else if (n % 2 == 0) begin
      chk(op == 2'd0, "R4 poll addr op", op, 0);
      chk(dat == 16'h2003, "R4 poll addr data", dat, 16'h2003);
      chk(cyc - lastRef == PD + 1, "R4 poll gap", cyc - lastRef, PD + 1);
    end else begin
      chk(op == 2'd2, "R4 read op", op, 2);
    end
    case (op)
      2'd0: begin
        int idx = addrIdx;
        addrIdx++;
        respond(errKind == 1 && errIdx == idx, $urandom, 1'b0);
      end
      2'd1: begin
        lastRef = cyc;
        @(posedge clk); #1;
        busyPoke = pokeBusy;
        @(posedge clk); #1;
        busyPoke = 1'b0;
        if (strayWrite) begin
          cmdDone = 1'b1; cmdErr = 1'b1;
          @(posedge clk); #1;
          cmdDone = 1'b0; cmdErr = 1'b0;
        end
      end
      default: begin
        readIdx++;
        rd = $urandom;
        rd[1] = (lockAt == readIdx);
        respond(errKind == 2 && errIdx == readIdx, rd, 1'b1);
      end
    endcase
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      while (rstN && cmdStart) handleCmd();
    end
  end

  function automatic void expectRun(input int lk, input int ek, input int ei,
                                    output bit to, output bit le, output int nc);
    to = 0; le = 0; nc = 1;
    if (ek == 1 && ei == 0) begin le = 1; return; end
    nc = 2;
    for (int p = 1; p <= MP; p++) begin
      nc++;
      if (ek == 1 && ei == p) begin le = 1; return; end
      nc++;
      if (ek == 2 && ei == p) begin le = 1; return; end
      if (lk == p) return;
    end
    to = 1;
  endfunction

  task automatic runCase(input int lk, input int ek, input int ei, input bit stray, input bit poke);
    bit eTo, eLe;
    int eNc, w, snap;
    lockAt = lk; errKind = ek; errIdx = ei; strayWrite = stray; pokeBusy = poke;
    nCmd = 0; addrIdx = 0; readIdx = 0;
    expectRun(lk, ek, ei, eTo, eLe, eNc);
    @(posedge clk); #1 startMain = 1'b1;
    @(posedge clk); #1 startMain = 1'b0;
    w = 0;
    while (!done && w < 5000) begin @(posedge clk); #1; w++; end
    chk(done == 1'b1, "R8 done seen", done, 1);
    // R5 R6 R7 outcome flags
    chk(timeoutErr == eTo, "R6 timeoutErr", timeoutErr, eTo);
    chk(linkErr == eLe, "R7 linkErr", linkErr, eLe);
    chk(nCmd == eNc, "R5 command count", nCmd, eNc);
    if (stray) chk(linkErr == eLe, "R3 stray response ignored", linkErr, eLe);
    if (poke)  chk(nCmd == eNc, "R9 busy start ignored", nCmd, eNc);
    snap = nCmd;
    @(posedge clk); #1;
    chk(done == 1'b0, "R8 done one cycle", done, 0);
    chk(timeoutErr == eTo && linkErr == eLe, "R8 flags held", {timeoutErr, linkErr}, {eTo, eLe});
    repeat (4) @(posedge clk);
    #1;
    chk(nCmd == snap && !cmdStart, "R10 no command after end", nCmd, snap);
  endtask

  initial begin
    int unsigned sd;
    sd = $urandom(32'd20240607);
    repeat (3) @(posedge clk);
    #1;
    chk(!done && !cmdStart && !timeoutErr && !linkErr, "R1 reset state",
        {done, cmdStart, timeoutErr, linkErr}, 0);
    rstN = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk(!done && !cmdStart, "R1 idle after reset", {done, cmdStart}, 0);
    // directed corners
    runCase(1, 0, 0, 0, 0);       // R5 lock on first poll
    runCase(MP, 0, 0, 0, 1);      // R5 lock on last poll, R9
    runCase(0, 0, 0, 0, 0);       // R6 never locks
    runCase(0, 1, 0, 0, 0);       // R7 error on reset address
    runCase(2, 2, 2, 0, 0);       // R7 error wins over lock bit
    runCase(3, 1, 3, 1, 0);       // R7 error on poll address, R3 stray
    runCase(1, 0, 0, 1, 1);       // R3 stray response after write
    for (int i = 0; i < 25; i++) begin
      int lk = int'($urandom % (MP + 2));
      int ek = ($urandom % 4 == 0) ? 1 + int'($urandom % 2) : 0;
      int ei = (ek == 1) ? int'($urandom % (MP + 1)) : 1 + int'($urandom % MP);
      runCase(lk, ek, ei, bit'($urandom % 2), bit'($urandom % 2));
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule